// File: doc/BRIEF.md
# Privilege Escalation Gate Checker

This block sits beside the fetch and decode stage of a processor and watches a stream of retired-instruction events, at most one per clock. Its job is to decide whether a transfer of control may raise the privilege level. It does not use a trap for this. Privilege may be raised only when two things happen in sequence. First, a jump retires whose target page carries the gate attribute in its already-resolved descriptor. Second, the very next retired instruction is the dedicated entry-marker instruction.

Any other retired instruction in between closes the window. So do a pipeline flush and an accepted privilege drop. Entering gate code past its marker therefore never grants anything.

The level is a 2-bit value in which 0 is the most privileged and 3 is user. An entry marker that executes while the window is closed does nothing at level 0. At any other level it produces a one-cycle fault pulse. Supervisor code lowers its own rights through a separate drop request. A drop request that would raise the level is ignored.

Top module: `privGate`

## Requirements
- R1: After reset, `privLevel` is 3 (user), `privFault` is low and the escalation window is closed.
- R2: A valid event with `evIsJump` high and `evTgtGate` high opens the window. A valid event with `evIsJump` high and `evTgtGate` low does not open it. When `evIsJump` is high, `evOpClass` is ignored.
- R3: The window lasts one instruction. Any valid event other than a gate jump closes it, including an ordinary instruction retired after the gate jump.
- R4: An entry marker is a valid event with `evIsJump` low and `evOpClass` equal to 2'b01. If it retires while the window is open, `privLevel` reads 0 from the clock edge that samples it, and no fault is raised.
- R5: An entry marker that retires while the window is closed and `privLevel` is not 0 drives `privFault` high for exactly the one cycle after that edge. It leaves `privLevel` unchanged.
- R6: An entry marker that retires while the window is closed at level 0 produces no fault and no change.
- R7: When `dropReq` is high and `dropLevel` is numerically greater than or equal to `privLevel`, the level becomes `dropLevel` at the next edge and the window closes. Otherwise the request has no effect.
- R8: `flush` closes the window without changing the level. It takes precedence over a gate jump in the same cycle.
- R9: Cycles with `evValid` low leave the window unchanged.
- R10: When a successful escalation and an accepted drop request fall in the same cycle, the escalation wins and the level becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | A retired-instruction event is present this cycle |
| evIsJump | input | 1 | The retired instruction was a jump |
| evOpClass | input | 2 | Opcode class of the retired instruction; 2'b01 is the entry marker |
| evTgtGate | input | 1 | Gate attribute from the descriptor of the jump target page |
| dropReq | input | 1 | Request to lower privilege |
| dropLevel | input | 2 | Requested level for a drop |
| flush | input | 1 | Pipeline flush; closes the window |
| privLevel | output | 2 | Current privilege level (0 most privileged) |
| privFault | output | 1 | One-cycle privilege-violation pulse |

## Verification
The bench aims at the edges of the one-instruction window. It places an ordinary instruction, an idle gap, a flush or a non-gate jump between the gate jump and the marker. A design with a sticky window would escalate after an intervening instruction. A design that treated idle cycles as instructions would refuse a legitimate entry. The bench also issues drop requests that would raise the level, issues a marker at level 0, and makes a drop collide with an escalation. A wrong comparison direction or a wrong priority shows up directly in the level, and a fault in supervisor mode shows up as a spurious pulse.

// File: rtl/privGatePkg.sv
package privGatePkg;
  localparam int LVL_W = 2;
  localparam int OP_W  = 2;
  localparam logic [OP_W-1:0] OP_ENTRY_MARK = 2'b01;

  typedef struct packed {
    logic escalate;
    logic dropLoad;
    logic faultSet;
  } gateStrobeT;
endpackage

// File: rtl/privGateCtrl.sv
module privGateCtrl
  import privGatePkg::*;
#(
  parameter int LW = LVL_W,
  parameter int OW = OP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          evValid,
  input  logic          evIsJump,
  input  logic [OW-1:0] evOpClass,
  input  logic          evTgtGate,
  input  logic          dropReq,
  input  logic [LW-1:0] dropLevel,
  input  logic          flush,
  input  logic [LW-1:0] curLevel,
  output gateStrobeT    strobe
);
  logic armQ;
  logic isMarker;
  logic gateJump;
  logic atTop;

  always_comb begin
    isMarker        = evValid && !evIsJump && (evOpClass == OP_ENTRY_MARK);
    gateJump        = evValid && evIsJump && evTgtGate;
    atTop           = (curLevel == '0);
    strobe.escalate = isMarker && armQ;
    strobe.faultSet = isMarker && !armQ && !atTop;
    strobe.dropLoad = dropReq && (dropLevel >= curLevel);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          armQ <= 1'b0;
    else if (flush || strobe.dropLoad)  armQ <= 1'b0;
    else if (evValid)                   armQ <= gateJump;
  end

  AST_WINDOW_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !(evIsJump && evTgtGate)) |=> !armQ); // R3
  AST_FLUSH_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !armQ); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!evValid && !flush && !(dropReq && dropLevel >= curLevel)) |=> $stable(armQ)); // R9
endmodule

// File: rtl/privGateData.sv
module privGateData
  import privGatePkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  gateStrobeT    strobe,
  input  logic [LW-1:0] dropLevel,
  output logic [LW-1:0] levelQ,
  output logic          faultQ
);
  localparam logic [LW-1:0] USER_LVL = {LW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= USER_LVL;
      faultQ <= 1'b0;
    end else begin
      faultQ <= strobe.faultSet;
      if (strobe.escalate)      levelQ <= '0;
      else if (strobe.dropLoad) levelQ <= dropLevel;
    end
  end

  AST_ESCALATE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.escalate |=> (levelQ == '0)); // R4
  AST_NO_RAISE_BY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.escalate |=> (levelQ >= $past(levelQ))); // R7
  AST_FAULT_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.faultSet && !strobe.dropLoad) |=> (faultQ && $stable(levelQ))); // R5
  AST_NO_FAULT_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> ($past(levelQ) != '0)); // R6
endmodule

// File: rtl/privGate.sv
module privGate
  import privGatePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic             evIsJump,
  input  logic [OP_W-1:0]  evOpClass,
  input  logic             evTgtGate,
  input  logic             dropReq,
  input  logic [LVL_W-1:0] dropLevel,
  input  logic             flush,
  output logic [LVL_W-1:0] privLevel,
  output logic             privFault
);
  gateStrobeT strobe;

  privGateCtrl #(.LW(LVL_W), .OW(OP_W)) ctrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evIsJump(evIsJump),
    .evOpClass(evOpClass), .evTgtGate(evTgtGate), .dropReq(dropReq),
    .dropLevel(dropLevel), .flush(flush), .curLevel(privLevel), .strobe(strobe)
  );

  privGateData #(.LW(LVL_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dropLevel(dropLevel),
    .levelQ(privLevel), .faultQ(privFault)
  );

  AST_RESET_USER: assert property (@(posedge clk)
    !rstN |=> (privLevel == 2'd3 && !privFault)); // R1
endmodule

// File: tb/privGate_test.sv
`timescale 1ns/1ps
module privGate_test;
  logic clk = 0;
  logic rstN = 0;
  logic evValid = 0, evIsJump = 0, evTgtGate = 0, dropReq = 0, flush = 0;
  logic [1:0] evOpClass = 0, dropLevel = 0;
  logic [1:0] privLevel;
  logic privFault;

  int checks = 0, fails = 0;
  bit timedOut = 0;
  int mLevel = 3;
  bit mArm = 0;
  bit mFault = 0;

  always #2 clk = ~clk;

  privGate uut (.*);

  task automatic cmp(string tag);
    checks++;
    if (privLevel !== 2'(mLevel)) begin
      fails++;
      $display("FAIL %s level actual=%0d expected=%0d", tag, privLevel, mLevel);
    end
    checks++;
    if (privFault !== mFault) begin
      fails++;
      $display("FAIL %s fault actual=%0b expected=%0b", tag, privFault, mFault);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare after it
  task automatic step(string tag, bit v, bit j, logic [1:0] op, bit g,
                      bit dr = 0, int dl = 0, bit fl = 0);
    bit mark, esc, dropOk;
    @(negedge clk);
    evValid = v; evIsJump = j; evOpClass = op; evTgtGate = g;
    dropReq = dr; dropLevel = 2'(dl); flush = fl;
    mark   = v && !j && (op == 2'b01);
    esc    = mark && mArm;
    mFault = mark && !mArm && (mLevel != 0);
    dropOk = dr && (dl >= mLevel);
    if (esc) mLevel = 0;
    else if (dropOk) mLevel = dl;
    if (fl || dropOk) mArm = 0;
    else if (v) mArm = j && g;
    @(posedge clk); #1;
    cmp(tag);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    evValid = 0; dropReq = 0; flush = 0;
    @(posedge clk); @(negedge clk); rstN = 1;
    mLevel = 3; mArm = 0; mFault = 0;
  endtask

  task automatic runAll();
    doReset();
    #1 cmp("R1 reset");
    step("R1 idle after reset", 0, 0, 0, 0);
    // R2 / R4: gate jump then marker escalates
    step("R2 gate jump", 1, 1, 2'b01, 1);
    step("R4 marker armed", 1, 0, 2'b01, 0);
    step("R6 marker at level 0 unarmed", 1, 0, 2'b01, 0);
    // R7 drops
    step("R7 drop to 2", 0, 0, 0, 0, 1, 2);
    step("R7 raising drop ignored", 0, 0, 0, 0, 1, 1);
    step("R7 equal drop accepted", 0, 0, 0, 0, 1, 2);
    // R3: intervening instruction closes window
    step("R3 gate jump", 1, 1, 0, 1);
    step("R3 ordinary instr", 1, 0, 2'b10, 0);
    step("R5 marker window closed", 1, 0, 2'b01, 0);
    step("R5 pulse one cycle", 0, 0, 0, 0);
    // R2: non-gate jump does not arm
    step("R2 non-gate jump", 1, 1, 0, 0);
    step("R2 marker after non-gate", 1, 0, 2'b01, 0);
    // R8 flush
    step("R8 gate jump", 1, 1, 0, 1);
    step("R8 flush only", 0, 0, 0, 0, 0, 0, 1);
    step("R8 marker after flush", 1, 0, 2'b01, 0);
    step("R8 flush with gate jump", 1, 1, 0, 1, 0, 0, 1);
    step("R8 marker after flush jump", 1, 0, 2'b01, 0);
    // R9 idle cycles hold window
    step("R9 gate jump", 1, 1, 0, 1);
    step("R9 idle", 0, 0, 0, 0);
    step("R9 idle", 0, 0, 0, 0);
    step("R9 marker after idle", 1, 0, 2'b01, 0);
    // R10: escalation beats drop
    step("R10 drop to 3", 0, 0, 0, 0, 1, 3);
    step("R10 gate jump", 1, 1, 0, 1);
    step("R10 marker with drop", 1, 0, 2'b01, 0, 1, 3);
    // R7: accepted drop closes window
    step("R7 gate jump", 1, 1, 0, 1);
    step("R7 drop alone", 0, 0, 0, 0, 1, 1);
    step("R7 marker after drop", 1, 0, 2'b01, 0);
    // R3: chained gate jumps keep window, then two markers
    step("R3 gate jump a", 1, 1, 0, 1);
    step("R3 gate jump b", 1, 1, 2'b01, 1);
    step("R3 marker", 1, 0, 2'b01, 0);
    step("R3 second marker", 1, 0, 2'b01, 0);
    step("R7 drop to 3", 0, 0, 0, 0, 1, 3);
    step("R5 back-to-back marker a", 1, 0, 2'b01, 0);
    step("R5 back-to-back marker b", 1, 0, 2'b01, 0);
    step("R5 settle", 0, 0, 0, 0);
    // R1 reset again
    doReset();
    #1 cmp("R1 second reset");
  endtask

  initial begin
    fork
      runAll();
      begin repeat (20000) @(posedge clk); timedOut = 1; end
    join_any
    if (timedOut) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule